// File: doc/BRIEF.md
# Mode-Dependent Baud Rate Generator

This block makes the timing ticks for a serial port. A host-programmed 8-bit value `n` sets a first-stage divider that produces a one-clock oversample tick every `n+1` system clocks. A second stage counts those oversample ticks and produces a one-clock bit tick after 4, 16 or 64 of them. The total division from the system clock to the bit tick is therefore `(n+1)` times 4, 16 or 64.

The second-stage factor comes from two control inputs. In synchronous mode the factor is always 4. In asynchronous mode a high-speed select picks 16 when it is set and 64 when it is clear. A divisor write, a change of either mode input, or a low port enable restarts both stages. The ticks that follow are therefore always a whole new period away from the event. The framing logic that consumes the ticks sits outside this block.

Top module: `baud_tick_gen`

## Requirements
- R1: While enabled and not restarted, `os_tick` is a one-clock pulse every `n+1` clocks. The first pulse is registered `n+1` clock edges after the restart edge.
- R2: With `sync_mode`=1 the factor is 4 whatever `fast_sel` is. `bit_tick` pulses on the clock after every 4th `os_tick`: first `4(n+1)+1` edges after restart, then every `4(n+1)`.
- R3: With `sync_mode`=0 and `fast_sel`=1 the factor is 16. The first `bit_tick` comes `16(n+1)+1` edges after restart, then one every `16(n+1)`.
- R4: With `sync_mode`=0 and `fast_sel`=0 the factor is 64. The first `bit_tick` comes `64(n+1)+1` edges after restart, then one every `64(n+1)`.
- R5: A clock edge that samples `divisor_wr`=1 stores `divisor_in` as the new `n` and restarts both stages. Both outputs are low on the following clock, and no tick of the old period appears afterwards.
- R6: With `n`=0, `os_tick` is high on every clock from the first edge after the restart edge onward.
- R7: While `port_en`=0 both outputs stay low and both stages are held in restart. The first edge with `port_en`=1 counts as edge 1 of a new period.
- R8: While enabled, a change of `sync_mode` or `fast_sel` restarts both stages with the held `n`, in the same way as R5.
- R9: Reset (`rst_n`=0, asynchronous) clears both outputs and sets `n` to 0.
- R10: `bit_tick` is high only on a clock directly after a clock on which `os_tick` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low holds the generator in restart |
| sync_mode | input | 1 | 1 = synchronous (factor 4), 0 = asynchronous |
| fast_sel | input | 1 | Asynchronous high-speed select: 1 = factor 16, 0 = factor 64 |
| divisor_wr | input | 1 | Write strobe for the divisor value |
| divisor_in | input | DIV_W | New divisor value `n` |
| os_tick | output | 1 | One-clock oversample tick every `n+1` clocks |
| bit_tick | output | 1 | One-clock bit-rate tick |

## Verification
The hardest situation to reach is a restart that lands partway through a period. Both counters then hold arbitrary nonzero values, and the stale count must not leak out as an early tick. The bench reaches this state in two ways. It lets a period run for a few clocks and then writes a new divisor. It also flips the high-speed select while the first stage is mid-count. In each case it measures the first and second oversample and bit ticks from the restart edge. It also counts every tick in the window, so a stray early pulse shows up as a count mismatch.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

  // Post-divider factor chosen by the two mode inputs.
  function automatic int post_factor(input logic sync_m, input logic fast_m,
                                     input int f_sync, input int f_fast,
                                     input int f_slow);
    if (sync_m)      return f_sync;
    else if (fast_m) return f_fast;
    else             return f_slow;
  endfunction

  // Total system clocks per bit tick.
  function automatic int total_div(input int n, input int factor);
    return (n + 1) * factor;
  endfunction

endpackage

// File: rtl/bgen_ctrl.sv
module bgen_ctrl #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             sync_mode,
  input  logic             fast_sel,
  input  logic             divisor_wr,
  input  logic [DIV_W-1:0] divisor_in,
  output logic             restart,
  output logic [DIV_W-1:0] load_val,
  output logic [DIV_W-1:0] div_q,
  output logic             sync_q,
  output logic             fast_q
);

  logic mode_chg;

  assign mode_chg = (sync_mode != sync_q) || (fast_sel != fast_q);
  assign restart  = !port_en || divisor_wr || mode_chg;
  assign load_val = divisor_wr ? divisor_in : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sync_q <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      sync_q <= sync_mode;
      fast_q <= fast_sel;
      if (divisor_wr) div_q <= divisor_in;
    end
  end

endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_q,
  output logic             os_tick
);

  logic [DIV_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else if (restart) begin
      cnt     <= load_val;
      os_tick <= 1'b0;
    end else begin
      os_tick <= at_zero;
      cnt     <= at_zero ? div_q : cnt - 1'b1;
    end
  end

  // R6: a zero divisor gives an oversample tick on every clock
  a_r6_zero_div_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(restart) && ($past(div_q) == '0) && ($past(cnt) == '0))
      |-> os_tick);

endmodule

// File: rtl/bgen_postscale.sv
module bgen_postscale
  import bgen_pkg::*;
#(
  parameter int F_SYNC = 4,
  parameter int F_FAST = 16,
  parameter int F_SLOW = 64,
  parameter int POST_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sync_q,
  input  logic fast_q,
  input  logic os_tick,
  output logic bit_tick
);

  logic [POST_W-1:0] pcnt;
  logic [POST_W-1:0] lim;
  logic              wrap;

  assign lim  = POST_W'(post_factor(sync_q, fast_q, F_SYNC, F_FAST, F_SLOW) - 1);
  assign wrap = os_tick && (pcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      bit_tick <= 1'b0;
    end else if (restart) begin
      pcnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= wrap;
      if (wrap)         pcnt <= '0;
      else if (os_tick) pcnt <= pcnt + 1'b1;
    end
  end

  // R10: a bit tick only follows an oversample tick
  a_r10_bit_follows_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(os_tick));

  // R4: the oversample count never passes the selected factor
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (pcnt <= lim));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W  = 8,
  parameter int F_SYNC = 4,
  parameter int F_FAST = 16,
  parameter int F_SLOW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             sync_mode,
  input  logic             fast_sel,
  input  logic             divisor_wr,
  input  logic [DIV_W-1:0] divisor_in,
  output logic             os_tick,
  output logic             bit_tick
);

  localparam int POST_W = $clog2(F_SLOW);

  logic             restart;
  logic [DIV_W-1:0] load_val;
  logic [DIV_W-1:0] div_q;
  logic             sync_q;
  logic             fast_q;

  bgen_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .fast_sel(fast_sel), .divisor_wr(divisor_wr), .divisor_in(divisor_in),
    .restart(restart), .load_val(load_val), .div_q(div_q),
    .sync_q(sync_q), .fast_q(fast_q)
  );

  bgen_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_val(load_val),
    .div_q(div_q), .os_tick(os_tick)
  );

  bgen_postscale #(
    .F_SYNC(F_SYNC), .F_FAST(F_FAST), .F_SLOW(F_SLOW), .POST_W(POST_W)
  ) u_post (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sync_q(sync_q),
    .fast_q(fast_q), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // R5: a divisor write silences both ticks on the next clock
  a_r5_write_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    divisor_wr |=> (!os_tick && !bit_tick));

  // R7: a disabled port produces no ticks
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!os_tick && !bit_tick));

  // R8: a mode change while enabled restarts the stages
  a_r8_mode_change_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ((sync_mode != sync_q) || (fast_sel != fast_q)))
      |=> (!os_tick && !bit_tick));

endmodule

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic       fast_sel = 1'b0;
  logic       divisor_wr = 1'b0;
  logic [7:0] divisor_in = 8'd0;
  logic       os_tick;
  logic       bit_tick;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .fast_sel(fast_sel), .divisor_wr(divisor_wr), .divisor_in(divisor_in),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // stimulus table: sync, fast, n, expected factor
  localparam int NV = 8;
  localparam int V_SYNC[NV] = '{1, 1, 0, 0, 0, 1, 0, 0};
  localparam int V_FAST[NV] = '{0, 1, 1, 0, 1, 0, 0, 0};
  localparam int V_N[NV]    = '{3, 0, 5, 2, 0, 255, 0, 255};
  localparam int V_FAC[NV]  = '{4, 4, 16, 64, 16, 4, 64, 64};

  task automatic check(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Called with c=0 being the restart edge; samples edges 1..W.
  task automatic measure(input int n, input int fac, input string tag);
    int per = n + 1;
    int win = 2 * fac * per + 2;
    int os1 = -1, os2 = -1, b1 = -1, b2 = -1, osn = 0, bn = 0;
    for (int c = 1; c <= win; c++) begin
      @(posedge clk);
      #1;
      if (os_tick) begin
        osn++;
        if (os1 < 0) os1 = c;
        else if (os2 < 0) os2 = c;
      end
      if (bit_tick) begin
        bn++;
        if (b1 < 0) b1 = c;
        else if (b2 < 0) b2 = c;
      end
    end
    check({tag, " R1 first os_tick"}, os1, per);
    check({tag, " R1 second os_tick"}, os2, 2 * per);
    check({tag, " R1 os_tick count"}, osn, win / per);
    check({tag, " first bit_tick"}, b1, fac * per + 1);
    check({tag, " second bit_tick"}, b2, 2 * fac * per + 1);
    check({tag, " bit_tick count"}, bn, 2);
  endtask

  task automatic write_div(input int n, input logic s, input logic f);
    @(negedge clk);
    sync_mode  = s;
    fast_sel   = f;
    divisor_in = 8'(n);
    divisor_wr = 1'b1;
    @(posedge clk);
    #2;
    divisor_wr = 1'b0;
  endtask

  function automatic string fac_tag(input int fac);
    if (fac == 4) return "R2";
    else if (fac == 16) return "R3";
    else return "R4";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 os_tick in reset", int'(os_tick), 0);
    check("R9 bit_tick in reset", int'(bit_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 os_tick after reset, disabled", int'(os_tick), 0);

    // R9: divisor resets to 0; enable in synchronous mode (R7 start edge)
    @(negedge clk);
    sync_mode = 1'b1;
    @(negedge clk);
    port_en = 1'b1;
    measure(0, 4, "R9 R7 default divisor");

    // table walk
    for (int v = 0; v < NV; v++) begin
      write_div(V_N[v], V_SYNC[v] != 0, V_FAST[v] != 0);
      measure(V_N[v], V_FAC[v], (V_N[v] == 0) ? {fac_tag(V_FAC[v]), " R6"} : fac_tag(V_FAC[v]));
    end

    // R5: write in the middle of a running period
    write_div(9, 1'b1, 1'b0);
    repeat (13) @(posedge clk);
    write_div(1, 1'b1, 1'b0);
    measure(1, 4, "R5 mid-period write");

    // R8: mode change mid-count with held divisor
    write_div(4, 1'b0, 1'b1);
    repeat (7) @(posedge clk);
    @(negedge clk);
    fast_sel = 1'b0;
    @(posedge clk);
    #2;
    measure(4, 64, "R8 mode change");

    // R2: fast_sel has no effect in synchronous mode
    write_div(2, 1'b1, 1'b1);
    measure(2, 4, "R2 fast_sel ignored");

    // R7: disabled holds outputs low, re-enable restarts
    write_div(3, 1'b0, 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    port_en = 1'b0;
    begin
      int seen = 0;
      for (int c = 0; c < 200; c++) begin
        @(posedge clk);
        #1;
        if (os_tick || bit_tick) seen++;
      end
      check("R7 ticks while disabled", seen, 0);
    end
    @(negedge clk);
    port_en = 1'b1;
    measure(3, 16, "R7 re-enable");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule